// File: doc/BRIEF.md
# BCD time and calendar counter

This block keeps wall-clock time and date in binary-coded decimal: seconds, minutes, hours, day of month, weekday, month with a century bit, and a two-digit year. A 1 Hz tick input advances the count. Days run up to the correct length of the current month, and February gains a 29th day in leap years. A host reads and writes the fields one byte at a time through a register port. Its byte pointer can be loaded and then steps by one after every byte.

A host holds `access_active` high for the whole of a multi-byte transaction. While it is high, no field advances, so a burst read cannot see a carry halfway through. One tick that arrives during that window is remembered and applied once the window closes. A supply-low input sets a sticky integrity flag in the top bit of the seconds byte, which only a host write can clear.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count 0x00..0x59 in BCD. A tick at 0x59 seconds gives 0x00 and advances minutes, and minutes roll the same way into hours.
- R2: Hours count 0x00..0x23. Rolling past 0x23 advances the day and the weekday. The weekday is a 3-bit binary value that counts 0..6 and then wraps to 0.
- R3: Days count from 0x01 up to the month length and then return to 0x01, advancing the month. Months 0x04, 0x06, 0x09 and 0x11 have 30 days, month 0x02 has 28 or 29, and all other months have 31.
- R4: February has 29 days when the BCD year is divisible by 4, including 0x00.
- R5: Months count 0x01..0x12, and rolling past 0x12 advances the year. The year counts 0x00..0x99, and rolling past 0x99 inverts the century bit (bit 7 of the month byte).
- R6: While `access_active` is high, no time field advances on a tick. A tick held during the window is applied at the first clock edge with `access_active` low. If a new tick arrives at that same edge, it is kept and applied at the next edge, so it is not lost.
- R7: Only one held tick is stored. Any further ticks in the same access window are dropped.
- R8: Bit 7 of the seconds byte is an integrity flag. `vlow` high sets it. A host write to the seconds byte loads it from data bit 7, and `vlow` wins when both happen in the same cycle.
- R9: Byte map: 0x2 seconds {flag, sec[6:0]}, 0x3 minutes [6:0], 0x4 hours [5:0], 0x5 day [5:0], 0x6 weekday [2:0], 0x7 {century, 2'b0, month[4:0]}, 0x8 year [7:0]. Bits outside these fields read 0. Other addresses read 0x00 and ignore writes.
- R10: `ptr_load` sets the pointer to `ptr_addr` and takes priority over a read or write strobe in the same cycle, which is then ignored. Otherwise each `wr_en` or `rd_en` cycle acts on the current address and then steps the pointer by one.
- R11: A field written with a value at or above its top value goes to its start value on the next increment and carries. A units digit of 9 or more carries into the tens digit.
- R12: After reset the bytes read: seconds 0x80 (flag set), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 with century 0, year 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse requesting a one-second advance |
| access_active | input | 1 | High while a host transaction is in progress; freezes the count |
| vlow | input | 1 | Supply-low indication; sets the integrity flag |
| ptr_load | input | 1 | Load the byte pointer from ptr_addr |
| ptr_addr | input | ADDR_W | New pointer value |
| wr_en | input | 1 | Write wdata at the pointer, then step the pointer |
| rd_en | input | 1 | Consume the byte at the pointer, then step the pointer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Byte at the current pointer |

## Verification
Two events can land in the same cycle: the release of an access window that holds a tick, and a fresh tick. The bench raises `tick_1hz` in the very cycle it drops `access_active`, then reads the seconds byte and expects an advance of exactly two. A second collision is a supply-low pulse held across a write that clears the flag. The bench writes bit 7 as 0 while `vlow` is high and expects the flag to read back as 1.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int A_SEC  = 2;
    localparam int A_MIN  = 3;
    localparam int A_HOUR = 4;
    localparam int A_DAY  = 5;
    localparam int A_WDAY = 6;
    localparam int A_MON  = 7;
    localparam int A_YEAR = 8;

    typedef struct packed {
        logic       vl;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic       cent;
        logic [4:0] mon;
        logic [7:0] year;
    } cal_time_t;

endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
    parameter int          W   = 7,
    parameter logic [W-1:0] BOT = '0
) (
    input  logic         en,
    input  logic [W-1:0] val,
    input  logic [W-1:0] top,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam int TW = W - 4;

    always_comb begin
        wrap = en && (val >= top);
        if (!en) begin
            nxt = val;
        end else if (val >= top) begin
            nxt = BOT;
        end else if (val[3:0] >= 4'd9) begin
            nxt = {val[W-1:4] + TW'(1), 4'h0};
        end else begin
            nxt = val + W'(1);
        end
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [4:0] mon,
    input  logic [4:0] year_lo,
    output logic [5:0] len
);
    logic [3:0] mod_sum;
    logic       leap;

    always_comb begin
        // ten's digit contributes 10*t = 2*t (mod 4)
        mod_sum = year_lo[3:0] + {2'b00, year_lo[4], 1'b0};
        leap    = (mod_sum[1:0] == 2'b00);
        case (mon)
            5'h02:                      len = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: len = 6'h30;
            default:                    len = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              access_active,
    input  logic              vlow,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    typedef struct packed {
        cal_time_t         t;
        logic              pend;
        logic [ADDR_W-1:0] ptr;
    } state_t;

    state_t st_q, st_d;

    logic       adv;
    logic [6:0] n_sec, n_min;
    logic [5:0] n_hour, n_day, mlen;
    logic [4:0] n_mon;
    logic [7:0] n_year;
    logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic       wsel;

    assign adv  = !access_active && (tick_1hz || st_q.pend);
    assign wsel = wr_en && !ptr_load;

    cal_bcd_field #(.W(7), .BOT(7'h00)) u_sec (
        .en(adv), .val(st_q.t.sec), .top(7'h59), .nxt(n_sec), .wrap(c_sec));
    cal_bcd_field #(.W(7), .BOT(7'h00)) u_min (
        .en(c_sec), .val(st_q.t.min), .top(7'h59), .nxt(n_min), .wrap(c_min));
    cal_bcd_field #(.W(6), .BOT(6'h00)) u_hour (
        .en(c_min), .val(st_q.t.hour), .top(6'h23), .nxt(n_hour), .wrap(c_hour));
    cal_month_len u_len (
        .mon(st_q.t.mon), .year_lo(st_q.t.year[4:0]), .len(mlen));
    cal_bcd_field #(.W(6), .BOT(6'h01)) u_day (
        .en(c_hour), .val(st_q.t.day), .top(mlen), .nxt(n_day), .wrap(c_day));
    cal_bcd_field #(.W(5), .BOT(5'h01)) u_mon (
        .en(c_day), .val(st_q.t.mon), .top(5'h12), .nxt(n_mon), .wrap(c_mon));
    cal_bcd_field #(.W(8), .BOT(8'h00)) u_year (
        .en(c_mon), .val(st_q.t.year), .top(8'h99), .nxt(n_year), .wrap(c_year));

    always_comb begin
        st_d = st_q;

        // counter advance
        st_d.t.sec  = n_sec;
        st_d.t.min  = n_min;
        st_d.t.hour = n_hour;
        st_d.t.day  = n_day;
        st_d.t.mon  = n_mon;
        st_d.t.year = n_year;
        st_d.t.cent = st_q.t.cent ^ c_year;
        if (c_hour) begin
            st_d.t.wday = (st_q.t.wday >= 3'd6) ? 3'd0 : st_q.t.wday + 3'd1;
        end

        // held tick: one slot, kept when a fresh tick meets the release
        if (access_active) begin
            st_d.pend = st_q.pend | tick_1hz;
        end else begin
            st_d.pend = st_q.pend & tick_1hz;
        end

        // host writes override the advance
        if (wsel) begin
            case (st_q.ptr)
                ADDR_W'(A_SEC):  begin st_d.t.sec = wdata[6:0]; st_d.t.vl = wdata[7]; end
                ADDR_W'(A_MIN):  st_d.t.min  = wdata[6:0];
                ADDR_W'(A_HOUR): st_d.t.hour = wdata[5:0];
                ADDR_W'(A_DAY):  st_d.t.day  = wdata[5:0];
                ADDR_W'(A_WDAY): st_d.t.wday = wdata[2:0];
                ADDR_W'(A_MON):  begin st_d.t.mon = wdata[4:0]; st_d.t.cent = wdata[7]; end
                ADDR_W'(A_YEAR): st_d.t.year = wdata;
                default: ;
            endcase
        end

        if (vlow) begin
            st_d.t.vl = 1'b1;
        end

        if (ptr_load) begin
            st_d.ptr = ptr_addr;
        end else if (wr_en || rd_en) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.t    <= '{vl: 1'b1, sec: 7'h00, min: 7'h00, hour: 6'h00, day: 6'h01,
                           wday: 3'd0, cent: 1'b0, mon: 5'h01, year: 8'h00};
            st_q.pend <= 1'b0;
            st_q.ptr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.ptr)
            ADDR_W'(A_SEC):  rdata = {st_q.t.vl, st_q.t.sec};
            ADDR_W'(A_MIN):  rdata = {1'b0, st_q.t.min};
            ADDR_W'(A_HOUR): rdata = {2'b00, st_q.t.hour};
            ADDR_W'(A_DAY):  rdata = {2'b00, st_q.t.day};
            ADDR_W'(A_WDAY): rdata = {5'b00000, st_q.t.wday};
            ADDR_W'(A_MON):  rdata = {st_q.t.cent, 2'b00, st_q.t.mon};
            ADDR_W'(A_YEAR): rdata = st_q.t.year;
            default:         rdata = 8'h00;
        endcase
    end

    // R6: frozen window keeps every time field unless the host writes
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (access_active && !wr_en) |=>
        $stable({st_q.t.sec, st_q.t.min, st_q.t.hour, st_q.t.day,
                 st_q.t.wday, st_q.t.cent, st_q.t.mon, st_q.t.year}));

    // R1: a valid seconds value stays in range across an advance
    p_sec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && st_q.t.sec <= 7'h59) |=> (st_q.t.sec <= 7'h59));

    // R7: a held tick survives further ticks inside the window
    p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && access_active) |=> st_q.pend);

    // R8: supply-low always leaves the flag set
    p_vl_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vlow |=> st_q.t.vl);

    // R10: a strobe without a load steps the pointer by one
    p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && (wr_en || rd_en)) |=> (st_q.ptr == ADDR_W'($past(st_q.ptr) + 1)));
endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       access_active = 1'b0;
    logic       vlow = 1'b0;
    logic       ptr_load = 1'b0;
    logic [3:0] ptr_addr = 4'h0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bcd_calendar #(.ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .access_active(access_active),
        .vlow(vlow), .ptr_load(ptr_load), .ptr_addr(ptr_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); ptr_load = 1'b1; ptr_addr = a;
        @(negedge clk); ptr_load = 1'b0; v = rdata; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); ptr_load = 1'b1; ptr_addr = a;
        @(negedge clk); ptr_load = 1'b0; wr_en = 1'b1; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d, w, mo, y);
        logic [7:0] v [7];
        v = '{s, m, h, d, w, mo, y};
        @(negedge clk); access_active = 1'b1; ptr_load = 1'b1; ptr_addr = 4'h2;
        @(negedge clk); ptr_load = 1'b0;
        for (int i = 0; i < 7; i++) begin
            wr_en = 1'b1; wdata = v[i];
            @(negedge clk);
        end
        wr_en = 1'b0; access_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic check_time(input string tag, input logic [7:0] s, m, h, d, w, mo, y);
        logic [7:0] v;
        rd(4'h2, v); check({tag, " sec"}, v, s);
        rd(4'h3, v); check({tag, " min"}, v, m);
        rd(4'h4, v); check({tag, " hour"}, v, h);
        rd(4'h5, v); check({tag, " day"}, v, d);
        rd(4'h6, v); check({tag, " wday"}, v, w);
        rd(4'h7, v); check({tag, " mon"}, v, mo);
        rd(4'h8, v); check({tag, " year"}, v, y);
    endtask

    task automatic test_reset_r12();
        check_time("R12 reset", 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    endtask

    task automatic test_map_r9();
        logic [7:0] v;
        rd(4'h0, v); check("R9 addr0", v, 8'h00);
        wr(4'hC, 8'hFF); rd(4'hC, v); check("R9 unmapped write", v, 8'h00);
        wr(4'h4, 8'hFF); rd(4'h4, v); check("R9 hour mask", v, 8'h3F);
        wr(4'h6, 8'hFF); rd(4'h6, v); check("R9 wday mask", v, 8'h07);
        wr(4'h3, 8'hFF); rd(4'h3, v); check("R9 min mask", v, 8'h7F);
        wr(4'h7, 8'hFF); rd(4'h7, v); check("R9 mon mask", v, 8'h9F);
    endtask

    task automatic test_pointer_r10();
        set_time(8'h10, 8'h20, 8'h05, 8'h07, 8'h02, 8'h03, 8'h40);
        @(negedge clk); ptr_load = 1'b1; ptr_addr = 4'h3;
        @(negedge clk); ptr_load = 1'b0;
        check("R10 load", rdata, 8'h20);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R10 step", rdata, 8'h05);
        ptr_load = 1'b1; ptr_addr = 4'h4; wr_en = 1'b1; wdata = 8'h11;
        @(negedge clk); ptr_load = 1'b0; wr_en = 1'b0;
        check("R10 load priority", rdata, 8'h05);
    endtask

    task automatic test_flag_r8();
        logic [7:0] v;
        rd(4'h2, v); check("R8 cleared by set", v, 8'h10);
        @(negedge clk); vlow = 1'b1;
        @(negedge clk); vlow = 1'b0;
        rd(4'h2, v); check("R8 set by vlow", v, 8'h90);
        vlow = 1'b1;
        wr(4'h2, 8'h10);
        vlow = 1'b0;
        rd(4'h2, v); check("R8 vlow beats write", v, 8'h90);
        wr(4'h2, 8'h10);
        rd(4'h2, v); check("R8 write clears", v, 8'h10);
    endtask

    task automatic test_secmin_r1();
        logic [7:0] v;
        set_time(8'h58, 8'h59, 8'h12, 8'h15, 8'h03, 8'h06, 8'h24);
        tick();
        rd(4'h2, v); check("R1 sec step", v, 8'h59);
        tick();
        check_time("R1 roll", 8'h00, 8'h00, 8'h13, 8'h15, 8'h03, 8'h06, 8'h24);
    endtask

    task automatic test_hours_r2();
        set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h06, 8'h24);
        tick();
        check_time("R2 midnight", 8'h00, 8'h00, 8'h00, 8'h16, 8'h00, 8'h06, 8'h24);
    endtask

    task automatic test_month_len_r3();
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h24);
        tick();
        check_time("R3 30-day", 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h05, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h05, 8'h24);
        tick();
        check_time("R3 31-day", 8'h00, 8'h00, 8'h00, 8'h31, 8'h02, 8'h05, 8'h24);
    endtask

    task automatic test_leap_r4();
        logic [7:0] v, d;
        logic [7:0] yrs [4];
        logic [7:0] expd [4];
        yrs  = '{8'h23, 8'h24, 8'h00, 8'h12};
        expd = '{8'h01, 8'h29, 8'h29, 8'h29};
        for (int i = 0; i < 4; i++) begin
            set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, yrs[i]);
            tick();
            rd(4'h5, d); check("R4 feb 28 next day", d, expd[i]);
        end
        set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h24);
        tick();
        rd(4'h5, d); check("R4 feb 29 next day", d, 8'h01);
        rd(4'h7, v); check("R4 feb 29 next month", v, 8'h03);
    endtask

    task automatic test_year_r5();
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h04, 8'h12, 8'h99);
        tick();
        check_time("R5 century set", 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h81, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h04, 8'h92, 8'h99);
        tick();
        check_time("R5 century clear", 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h01, 8'h00);
    endtask

    task automatic test_freeze_r6();
        logic [7:0] v;
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
        @(negedge clk); access_active = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'h2, v); check("R6 frozen", v, 8'h10);
        access_active = 1'b0;
        rd(4'h2, v); check("R6 applied after release", v, 8'h11);
        // release and fresh tick in the same cycle
        @(negedge clk); access_active = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk); access_active = 1'b0; tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        rd(4'h2, v); check("R6 collision keeps both", v, 8'h13);
    endtask

    task automatic test_single_slot_r7();
        logic [7:0] v;
        set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
        @(negedge clk); access_active = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
        @(negedge clk); access_active = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'h2, v); check("R7 one held tick", v, 8'h21);
    endtask

    task automatic test_out_of_range_r11();
        logic [7:0] v;
        set_time(8'h75, 8'h10, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
        tick();
        rd(4'h2, v); check("R11 sec wraps", v, 8'h00);
        rd(4'h3, v); check("R11 carry", v, 8'h11);
        wr(4'h2, 8'h1C);
        tick();
        rd(4'h2, v); check("R11 units carry", v, 8'h20);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset_r12();
        test_map_r9();
        test_pointer_r10();
        test_flag_r8();
        test_secmin_r1();
        test_hours_r2();
        test_month_len_r3();
        test_leap_r4();
        test_year_r5();
        test_freeze_r6();
        test_single_slot_r7();
        test_out_of_range_r11();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule